// File: doc/BRIEF.md
# Beacon Target Time Scheduler

This block keeps a free-running 64-bit microsecond timestamp and uses it to schedule periodic beacon target times. Software programs a target time, a beacon interval and a lead time through a small register port. Each microsecond tick advances the timestamp by one. When the timestamp nears the target, the block raises a prepare condition. When it reaches the target, the block pulses an expiry condition and computes the following target by itself.

A short sequencer of five states does the scheduling. `ST_IDLE` waits for a non-zero interval and goes to `ST_WAIT`. `ST_WAIT` compares the timestamp with the early point (target minus lead) and goes to `ST_LEAD` when that point is reached. `ST_LEAD` holds the prepare condition and goes to `ST_ROLL` once the target is reached. `ST_ROLL` pulses the expiry, copies the target into the previous-start register and sets the sticky flag, then goes to `ST_NEXT`. `ST_NEXT` writes previous start plus the period into the target, reloads the countdown and returns to `ST_WAIT`.

Three transitions lead back to `ST_IDLE`. A zero interval seen in `ST_WAIT` or `ST_LEAD` returns there. Any write to the target, interval or lead registers also returns there, from any state. A 64-bit timestamp read stays consistent because reading the low word captures the high word in a shadow register.

Top module: `bcn_sched`

## Requirements
- R1: After reset the timestamp, target, previous start, interval, lead and countdown read 0. The status word reads 0x8000, and `prep_o`, `expire_o` and `sticky_o` are low.
- R2: The timestamp grows by exactly one on each clock where `us_tick` is high and no timestamp write occurs, with carry across the 32-bit halves.
- R3: A read of address 0 returns timestamp bits 31:0 and captures bits 63:32 into a shadow register. A read of address 1 returns that shadow, not the live high word.
- R4: Writes to address 0 and address 1 replace timestamp bits 31:0 and 63:32 respectively.
- R5: `prep_o` is high while the sequencer waits between the early point and the target. The early point is the target minus the lead in µs. `prep_o` rises after the timestamp reaches the early point and falls when expiry begins.
- R6: `expire_o` is a one-clock pulse. It is issued once per target, after the timestamp reaches the target, and only after `prep_o` was high on the previous clock.
- R7: On expiry the previous start (addresses 4/5, low/high) takes the old target. The target (addresses 2/3) then becomes the new previous start plus interval × 2^UNIT_LOG2. This repeats for every period.
- R8: The status word (address 8) changes from 0x8000 to 0x8600 at the first expiry, and `sticky_o` rises with it. Neither ever returns until reset, and a write to address 8 has no effect.
- R9: The countdown (address 9) is reloaded with interval × 2^UNIT_LOG2 on each expiry. It falls by one per tick and stops at 0.
- R10: While the interval (address 6) is 0, neither `prep_o` nor `expire_o` is ever asserted.
- R11: If the lead (address 7) exceeds the target, the early point is 0, so `prep_o` rises as soon as scheduling starts.
- R12: Interval, lead, target and previous-start registers read back the value written. A write to the target, interval or lead returns the sequencer to its idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-microsecond enable for the timestamp |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the low-word capture) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| prep_o | output | 1 | Prepare-beacon condition |
| expire_o | output | 1 | Target-time expiry pulse |
| sticky_o | output | 1 | Set after the first expiry |

## Verification
The bench sweeps every lead from 0 to two past one period, for several small intervals, with a short time unit. This covers leads larger than the target, which a design without the early-point clamp would wrap around and never prepare for. It also covers leads longer than a period, where a design that gates prepare on a fresh state entry would miss the immediate re-prepare. After each tick the bench compares prepare and a running count of expiries against an arithmetic model. An off-by-one period or a computation from the wrong base register shows up as a drifted target or previous start. A capture of the high word at the wrong time shows up as a torn timestamp across a 32-bit carry. A status word that can be cleared by a write also fails its check.

// File: rtl/bcn_pkg.sv
package bcn_pkg;

    localparam int REG_AW = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LEAD,
        ST_ROLL,
        ST_NEXT
    } seq_state_e;

    localparam logic [REG_AW-1:0] ADR_TS_LO   = 4'd0;
    localparam logic [REG_AW-1:0] ADR_TS_HI   = 4'd1;
    localparam logic [REG_AW-1:0] ADR_TGT_LO  = 4'd2;
    localparam logic [REG_AW-1:0] ADR_TGT_HI  = 4'd3;
    localparam logic [REG_AW-1:0] ADR_PRV_LO  = 4'd4;
    localparam logic [REG_AW-1:0] ADR_PRV_HI  = 4'd5;
    localparam logic [REG_AW-1:0] ADR_INTV    = 4'd6;
    localparam logic [REG_AW-1:0] ADR_LEAD    = 4'd7;
    localparam logic [REG_AW-1:0] ADR_STATUS  = 4'd8;
    localparam logic [REG_AW-1:0] ADR_CDOWN   = 4'd9;

    localparam logic [15:0] STAT_FRESH = 16'h8000;
    localparam logic [15:0] STAT_RUN   = 16'h8600;

endpackage

// File: rtl/bcn_tsf.sv
module bcn_tsf #(
    parameter int TS_W = 64,
    parameter int DW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic                 rd_lo,
    input  logic [DW-1:0]        wdata,
    output logic [TS_W-1:0]      ts,
    output logic [TS_W-DW-1:0]   shadow_hi
);
    localparam int HI_W = TS_W - DW;

    logic [TS_W-1:0] ts_d;

    always_comb begin
        ts_d = ts;
        if (wr_lo) begin
            ts_d[DW-1:0] = wdata;
        end else if (wr_hi) begin
            ts_d[TS_W-1:DW] = wdata[HI_W-1:0];
        end else if (tick) begin
            ts_d = ts + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts        <= '0;
            shadow_hi <= '0;
        end else begin
            ts <= ts_d;
            if (rd_lo) begin
                shadow_hi <= ts[TS_W-1:DW];
            end
        end
    end
endmodule

// File: rtl/bcn_cfg.sv
module bcn_cfg #(
    parameter int DW     = 32,
    parameter int INTV_W = 16,
    parameter int LEAD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_intv,
    input  logic              wr_lead,
    input  logic [DW-1:0]     wdata,
    output logic [INTV_W-1:0] intv,
    output logic [LEAD_W-1:0] lead
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intv <= '0;
            lead <= '0;
        end else begin
            if (wr_intv) begin
                intv <= wdata[INTV_W-1:0];
            end
            if (wr_lead) begin
                lead <= wdata[LEAD_W-1:0];
            end
        end
    end
endmodule

// File: rtl/bcn_seq.sv
module bcn_seq
    import bcn_pkg::*;
#(
    parameter int TS_W      = 64,
    parameter int DW        = 32,
    parameter int INTV_W    = 16,
    parameter int LEAD_W    = 16,
    parameter int UNIT_LOG2 = 10,
    parameter int CD_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic [TS_W-1:0]   ts,
    input  logic [INTV_W-1:0] intv,
    input  logic [LEAD_W-1:0] lead,
    input  logic              wr_cur_lo,
    input  logic              wr_cur_hi,
    input  logic              wr_prev_lo,
    input  logic              wr_prev_hi,
    input  logic [DW-1:0]     wdata,
    output logic [TS_W-1:0]   cur,
    output logic [TS_W-1:0]   prev,
    output logic [CD_W-1:0]   cdown,
    output logic              prep,
    output logic              expire,
    output logic              sticky,
    output logic [15:0]       status
);
    localparam int HI_W = TS_W - DW;

    seq_state_e st_q, st_d;

    logic [TS_W-1:0] period;
    logic [TS_W-1:0] lead_ext;
    logic [TS_W-1:0] early;
    logic            hit_early;
    logic            hit_target;
    logic            run_en;

    assign period     = TS_W'(intv) << UNIT_LOG2;
    assign lead_ext   = TS_W'(lead);
    assign early      = (lead_ext > cur) ? '0 : (cur - lead_ext);
    assign hit_early  = (ts >= early);
    assign hit_target = (ts >= cur);
    assign run_en     = (intv != '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (run_en) st_d = ST_WAIT;
            ST_WAIT: begin
                if (!run_en)        st_d = ST_IDLE;
                else if (hit_early) st_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (!run_en)         st_d = ST_IDLE;
                else if (hit_target) st_d = ST_ROLL;
            end
            ST_ROLL: st_d = ST_NEXT;
            ST_NEXT: st_d = ST_WAIT;
            default: st_d = ST_IDLE;
        endcase
        if (restart) begin
            st_d = ST_IDLE;
        end
    end

    // schedule data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= '0;
            prev   <= '0;
            cdown  <= '0;
            sticky <= 1'b0;
        end else begin
            if (wr_prev_lo) begin
                prev[DW-1:0] <= wdata;
            end else if (wr_prev_hi) begin
                prev[TS_W-1:DW] <= wdata[HI_W-1:0];
            end else if (st_q == ST_ROLL) begin
                prev <= cur;
            end

            if (st_q == ST_ROLL) begin
                sticky <= 1'b1;
            end

            if (wr_cur_lo) begin
                cur[DW-1:0] <= wdata;
            end else if (wr_cur_hi) begin
                cur[TS_W-1:DW] <= wdata[HI_W-1:0];
            end else if (st_q == ST_NEXT) begin
                cur <= prev + period;
            end

            if (st_q == ST_NEXT) begin
                cdown <= period[CD_W-1:0];
            end else if (tick && (cdown != '0)) begin
                cdown <= cdown - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        prep   = (st_q == ST_LEAD);
        expire = (st_q == ST_ROLL);
        status = sticky ? STAT_RUN : STAT_FRESH;
    end
endmodule

// File: rtl/bcn_sched.sv
module bcn_sched
    import bcn_pkg::*;
#(
    parameter int TS_W      = 64,
    parameter int DW        = 32,
    parameter int INTV_W    = 16,
    parameter int LEAD_W    = 16,
    parameter int UNIT_LOG2 = 10,
    parameter int CD_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              prep_o,
    output logic              expire_o,
    output logic              sticky_o
);
    localparam int HI_W = TS_W - DW;

    logic [TS_W-1:0]   ts_w;
    logic [HI_W-1:0]   shadow_w;
    logic [TS_W-1:0]   cur_w;
    logic [TS_W-1:0]   prev_w;
    logic [CD_W-1:0]   cdown_w;
    logic [INTV_W-1:0] intv_w;
    logic [LEAD_W-1:0] lead_w;
    logic [15:0]       status_w;

    logic wr_ts_lo, wr_ts_hi, wr_ts_any;
    logic wr_tgt_lo, wr_tgt_hi, wr_prv_lo, wr_prv_hi;
    logic wr_intv, wr_lead, rd_ts_lo, restart;

    assign wr_ts_lo  = reg_wr && (reg_addr == ADR_TS_LO);
    assign wr_ts_hi  = reg_wr && (reg_addr == ADR_TS_HI);
    assign wr_ts_any = wr_ts_lo || wr_ts_hi;
    assign wr_tgt_lo = reg_wr && (reg_addr == ADR_TGT_LO);
    assign wr_tgt_hi = reg_wr && (reg_addr == ADR_TGT_HI);
    assign wr_prv_lo = reg_wr && (reg_addr == ADR_PRV_LO);
    assign wr_prv_hi = reg_wr && (reg_addr == ADR_PRV_HI);
    assign wr_intv   = reg_wr && (reg_addr == ADR_INTV);
    assign wr_lead   = reg_wr && (reg_addr == ADR_LEAD);
    assign rd_ts_lo  = reg_rd && (reg_addr == ADR_TS_LO);
    assign restart   = wr_tgt_lo || wr_tgt_hi || wr_intv || wr_lead;

    bcn_tsf #(.TS_W(TS_W), .DW(DW)) u_tsf (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (us_tick),
        .wr_lo     (wr_ts_lo),
        .wr_hi     (wr_ts_hi),
        .rd_lo     (rd_ts_lo),
        .wdata     (reg_wdata),
        .ts        (ts_w),
        .shadow_hi (shadow_w)
    );

    bcn_cfg #(.DW(DW), .INTV_W(INTV_W), .LEAD_W(LEAD_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_intv (wr_intv),
        .wr_lead (wr_lead),
        .wdata   (reg_wdata),
        .intv    (intv_w),
        .lead    (lead_w)
    );

    bcn_seq #(
        .TS_W(TS_W), .DW(DW), .INTV_W(INTV_W), .LEAD_W(LEAD_W),
        .UNIT_LOG2(UNIT_LOG2), .CD_W(CD_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (us_tick),
        .restart    (restart),
        .ts         (ts_w),
        .intv       (intv_w),
        .lead       (lead_w),
        .wr_cur_lo  (wr_tgt_lo),
        .wr_cur_hi  (wr_tgt_hi),
        .wr_prev_lo (wr_prv_lo),
        .wr_prev_hi (wr_prv_hi),
        .wdata      (reg_wdata),
        .cur        (cur_w),
        .prev       (prev_w),
        .cdown      (cdown_w),
        .prep       (prep_o),
        .expire     (expire_o),
        .sticky     (sticky_o),
        .status     (status_w)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_TS_LO:  reg_rdata = ts_w[DW-1:0];
            ADR_TS_HI:  reg_rdata = DW'(shadow_w);
            ADR_TGT_LO: reg_rdata = cur_w[DW-1:0];
            ADR_TGT_HI: reg_rdata = DW'(cur_w[TS_W-1:DW]);
            ADR_PRV_LO: reg_rdata = prev_w[DW-1:0];
            ADR_PRV_HI: reg_rdata = DW'(prev_w[TS_W-1:DW]);
            ADR_INTV:   reg_rdata = DW'(intv_w);
            ADR_LEAD:   reg_rdata = DW'(lead_w);
            ADR_STATUS: reg_rdata = DW'(status_w);
            ADR_CDOWN:  reg_rdata = DW'(cdown_w);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bcn_sched_chk.sv
module bcn_sched_chk #(
    parameter int TS_W   = 64,
    parameter int INTV_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              us_tick,
    input logic              reg_wr,
    input logic              ts_wr,
    input logic [TS_W-1:0]   ts,
    input logic [TS_W-1:0]   cur,
    input logic [TS_W-1:0]   prev,
    input logic [INTV_W-1:0] intv,
    input logic [15:0]       status,
    input logic              prep,
    input logic              expire,
    input logic              sticky
);
    p_ts_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (us_tick && !ts_wr) |=> (ts == $past(ts) + 1'b1));

    p_prep_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> $past(prep));

    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(expire && prep));

    p_prev_takes_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !reg_wr) |=> (prev == $past(cur)));

    p_sticky_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sticky |=> sticky);

    p_status_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sticky ? (status == 16'h8600) : (status == 16'h8000));

    p_sticky_on_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> sticky);

    p_zero_interval_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (intv == '0) |-> (!prep && !expire));
endmodule

bind bcn_sched bcn_sched_chk #(.TS_W(TS_W), .INTV_W(INTV_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .us_tick (us_tick),
    .reg_wr  (reg_wr),
    .ts_wr   (wr_ts_any),
    .ts      (ts_w),
    .cur     (cur_w),
    .prev    (prev_w),
    .intv    (intv_w),
    .status  (status_w),
    .prep    (prep_o),
    .expire  (expire_o),
    .sticky  (sticky_o)
);

// File: tb/sim_bcn_sched.sv
module sim_bcn_sched;
    localparam int ULOG = 3;
    localparam int UNIT = 1 << ULOG;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        prep_o, expire_o, sticky_o;

    int nchk = 0;
    int nerr = 0;
    int exp_cnt = 0;

    always #4 clk = ~clk;

    bcn_sched #(.UNIT_LOG2(ULOG)) u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .prep_o(prep_o), .expire_o(expire_o), .sticky_o(sticky_o)
    );

    always @(negedge clk) if (expire_o === 1'b1) exp_cnt <= exp_cnt + 1;

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tick_one();
        @(negedge clk);
        us_tick = 1'b1;
        @(negedge clk);
        us_tick = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr + 1, nchk + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        longint unsigned mts, mcur, mprev, mcd, early;
        int base, mcnt;
        bit rolled;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 prep", prep_o, 0);
        chk("R1 expire", expire_o, 0);
        chk("R1 sticky", sticky_o, 0);
        rd(4'd0, d); chk("R1 ts", d, 0);
        rd(4'd6, d); chk("R1 interval", d, 0);
        rd(4'd8, d); chk("R1 status", d, 32'h8000);
        rd(4'd9, d); chk("R1 countdown", d, 0);

        // R4 writes, R3 atomic read, R2 carry
        wr(4'd0, 32'hFFFF_FFFE);
        wr(4'd1, 32'h0000_0007);
        rd(4'd0, d); chk("R4 ts low", d, 32'hFFFF_FFFE);
        tick_one(); tick_one();
        rd(4'd1, d); chk("R3 shadow high", d, 32'h7);
        rd(4'd0, d); chk("R2 carry low", d, 0);
        rd(4'd1, d); chk("R2 carry high", d, 32'h8);
        for (int k = 0; k < 5; k++) tick_one();
        rd(4'd0, d); chk("R2 five ticks", d, 5);

        // R12 readback
        wr(4'd7, 32'h0000_ABCD); rd(4'd7, d); chk("R12 lead", d, 32'hABCD);
        wr(4'd4, 32'h1357_2468); rd(4'd4, d); chk("R12 prev low", d, 32'h1357_2468);
        wr(4'd5, 32'h0000_0042); rd(4'd5, d); chk("R12 prev high", d, 32'h42);
        wr(4'd3, 32'h0000_0099); rd(4'd3, d); chk("R12 target high", d, 32'h99);

        // R10 zero interval: no conditions
        wr(4'd0, 0); wr(4'd1, 0); wr(4'd2, 3); wr(4'd3, 0); wr(4'd7, 2);
        base = exp_cnt;
        for (int k = 0; k < 20; k++) begin
            tick_one();
            chk("R10 prep stays low", prep_o, 0);
        end
        chk("R10 no expiry", exp_cnt - base, 0);
        rd(4'd8, d); chk("R8 status before expiry", d, 32'h8000);

        // sweep intervals and leads
        for (int iv = 1; iv <= 4; iv++) begin
            for (int ld = 0; ld <= iv * UNIT + 2; ld++) begin
                wr(4'd6, 0);
                wr(4'd0, 0); wr(4'd1, 0);
                wr(4'd2, 5); wr(4'd3, 0);
                wr(4'd7, ld);
                wr(4'd6, iv);
                repeat (8) @(negedge clk);
                mts = 0; mcur = 5; mprev = 0; mcd = 0; mcnt = 0; rolled = 0;
                base = exp_cnt;
                early = (ld > mcur) ? 0 : mcur - ld;
                chk(ld > 5 ? "R11 clamped prep at start" : "R5 prep at start",
                    prep_o, (mts >= early));
                for (int k = 0; k < iv * 3 * UNIT; k++) begin
                    tick_one();
                    mts++;
                    if (rolled && mcd > 0) mcd--;
                    if (mts >= mcur) begin
                        mprev = mcur;
                        mcur = mcur + iv * UNIT;
                        mcnt++;
                        rolled = 1;
                        mcd = iv * UNIT;
                    end
                    early = (ld > mcur) ? 0 : mcur - ld;
                    chk("R5 prep level", prep_o, (mts >= early));
                    chk("R6 expiry count", exp_cnt - base, mcnt);
                end
                rd(4'd6, d); chk("R12 interval", d, iv);
                rd(4'd4, d); chk("R7 previous start", d, mprev);
                rd(4'd2, d); chk("R7 next target", d, mcur);
                rd(4'd9, d); chk("R9 countdown", d, mcd);
            end
        end

        // R8 sticky status
        chk("R8 sticky", sticky_o, 1);
        rd(4'd8, d); chk("R8 status after expiry", d, 32'h8600);
        wr(4'd8, 0);
        rd(4'd8, d); chk("R8 status write ignored", d, 32'h8600);
        wr(4'd6, 0);
        repeat (4) @(negedge clk);
        chk("R8 sticky after disable", sticky_o, 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule